// File: doc/BRIEF.md
# Periodic Comparator Timer Channel

This block is a 32-bit free-running counter paired with a single timer channel, all reached through a small register port. Software starts and stops the counter with a run bit. It programs the channel with an absolute comparator value and a separate period value. When the running counter reaches the comparator, the channel raises a pending interrupt. In periodic mode the channel also adds the period to the comparator, which sets up the next match without any further software action.

A plain comparator write loads the comparator and the period together. That only gives a correct period when the counter sits at zero. A self-clearing set-value control bit removes this restriction. With the bit set, the first comparator write places the absolute target and the second write places only the period. Software can therefore write counter-plus-period followed by the period and get an evenly spaced interrupt train starting from wherever the counter stands. A stored legacy-routing enable and a capability flag are kept as register state only; no routing logic is built here.

Register map (3-bit word address): 0 capability, 1 general config, 2 status, 3 main counter, 4 channel config, 5 comparator, 6 period (read only). A read returns data in the same cycle the address is presented (combinational). A write takes effect at the next rising clock edge while `wrEn` is high.

Top module: `cmp_timer`

## Requirements
- R1: General config (address 1) bit 0 is the run bit. While it is 1 the counter at address 3 advances by one each clock, wrapping modulo 2^32. While it is 0 the counter holds its value. A write to address 3 loads the counter. All registers read 0 after reset, except the comparator, which resets to all ones.
- R2: Capability register (address 0) bit 0 reads 1 when the LEGACY_CAP parameter is 1, and writes to it have no effect. General config bit 1 is the legacy-routing enable; it stores a written 1 only when LEGACY_CAP is 1. All other general config bits read 0.
- R3: Channel config (address 4) bit 2 is interrupt enable, bit 3 is periodic mode, bit 6 is set-value and bit 8 is 32-bit mode. Each of these bits reads back what was written, and every other bit reads 0.
- R4: While set-value is 0, a write to address 5 loads both the comparator (read at address 5) and the period (read at address 6).
- R5: Set-value works as a two-write sequence. After set-value is written as 1, the first write to address 5 loads only the comparator, and the set-value bit still reads 1. The second write to address 5 loads only the period, and set-value then reads 0. Any write to channel config restarts the sequence.
- R6: In periodic mode, every match adds the period to the comparator modulo 2^32. Suppose the stopped counter holds C, and the sequence C+P then P is written with set-value. When the counter is then started, the first interrupt is pending P+1 clocks after the starting write, and each later interrupt follows exactly P clocks after the one before.
- R7: A match is tested only while the run bit is 1. A comparator value that the counter passed while stopped, or that lies below a freshly loaded counter, fires only after the counter wraps around to it.
- R8: On a match with interrupt enable set, status bit 0 (address 2) becomes 1 one clock later, and output `irq` follows status bit 0. Writing 1 to status bit 0 clears it, and writing 0 has no effect. A match with interrupt enable clear leaves status at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| wrEn | input | 1 | Write strobe for the addressed register |
| addr | input | 3 | Register word address |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Read data for `addr`, combinational |
| irq | output | 1 | Level interrupt, equals status bit 0 |

## Verification
A register write is complete at the first rising edge after `wrEn` is driven. Reads are combinational, so the bench reads in the low phase of that same cycle. The counter moves once per edge, so after the k-th edge that follows the starting write it holds its start value plus k. A match at counter value V is registered at the edge after the counter shows V, so `irq` is first visible one edge later than a naive count suggests. The bench uses this to predict exact edge numbers: 41 edges for a 40-cycle period from the starting write, and 12 and 17 edges in the wrap case. It samples `irq` at the falling edge just before and just after the predicted edge.

// File: rtl/cmp_timer_pkg.sv
package cmp_timer_pkg;

  typedef enum logic [2:0] {
    RA_CAP   = 3'd0,
    RA_GEN   = 3'd1,
    RA_STAT  = 3'd2,
    RA_CNT   = 3'd3,
    RA_CHCFG = 3'd4,
    RA_CMP   = 3'd5,
    RA_PER   = 3'd6
  } regAddrE;

  localparam int GEN_RUN_B  = 0;
  localparam int GEN_LEG_B  = 1;
  localparam int CH_IRQEN_B = 2;
  localparam int CH_PER_B   = 3;
  localparam int CH_SETV_B  = 6;
  localparam int CH_M32_B   = 8;
  localparam int STAT_B     = 0;

  typedef struct packed {
    logic cntLoad;
    logic cmpLoad;
    logic perLoad;
    logic run;
    logic periodic;
  } dpStrobeT;

endpackage

// File: rtl/cmp_timer_dp.sv
module cmp_timer_dp
  import cmp_timer_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobeT          stb,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] count,
  output logic [DATA_W-1:0] cmpVal,
  output logic [DATA_W-1:0] perVal,
  output logic              hit
);

  assign hit = stb.run && (count == cmpVal);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      count <= '0;
    end else if (stb.cntLoad) begin
      count <= wdata;
    end else if (stb.run) begin
      count <= count + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmpVal <= '1;
    end else if (stb.cmpLoad) begin
      cmpVal <= wdata;
    end else if (hit && stb.periodic) begin
      cmpVal <= cmpVal + perVal;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      perVal <= '0;
    end else if (stb.perLoad) begin
      perVal <= wdata;
    end
  end

  AST_COUNT_FROZEN: assert property (@(posedge clk) disable iff (!rstN)
    (!stb.run && !stb.cntLoad) |=> $stable(count)); // R1
  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (stb.run && !stb.cntLoad) |=> (count == $past(count) + 1'b1)); // R1
  AST_PERIOD_RELOAD: assert property (@(posedge clk) disable iff (!rstN)
    (hit && stb.periodic && !stb.cmpLoad) |=> (cmpVal == $past(cmpVal) + $past(perVal))); // R6
  AST_PERIOD_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !stb.perLoad |=> $stable(perVal)); // R5

endmodule

// File: rtl/cmp_timer_ctrl.sv
module cmp_timer_ctrl
  import cmp_timer_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter bit LEGACY_CAP = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [2:0]        addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              hitIn,
  input  logic [DATA_W-1:0] cntIn,
  input  logic [DATA_W-1:0] cmpIn,
  input  logic [DATA_W-1:0] perIn,
  output dpStrobeT          stb,
  output logic [DATA_W-1:0] rdata,
  output logic              irqOut
);

  logic genRun, genLegacy;
  logic chIrqEn, chPeriodic, chSetVal, chMode32;
  logic setPhase;
  logic irqPend;

  logic wrGen, wrStat, wrChCfg, wrCmp;
  assign wrGen   = wrEn && (addr == RA_GEN);
  assign wrStat  = wrEn && (addr == RA_STAT);
  assign wrChCfg = wrEn && (addr == RA_CHCFG);
  assign wrCmp   = wrEn && (addr == RA_CMP);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      genRun    <= 1'b0;
      genLegacy <= 1'b0;
    end else if (wrGen) begin
      genRun    <= wdata[GEN_RUN_B];
      genLegacy <= wdata[GEN_LEG_B] & LEGACY_CAP;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      chIrqEn    <= 1'b0;
      chPeriodic <= 1'b0;
      chSetVal   <= 1'b0;
      chMode32   <= 1'b0;
      setPhase   <= 1'b0;
    end else if (wrChCfg) begin
      chIrqEn    <= wdata[CH_IRQEN_B];
      chPeriodic <= wdata[CH_PER_B];
      chSetVal   <= wdata[CH_SETV_B];
      chMode32   <= wdata[CH_M32_B];
      setPhase   <= 1'b0;
    end else if (wrCmp && chSetVal) begin
      if (setPhase) begin
        chSetVal <= 1'b0;
        setPhase <= 1'b0;
      end else begin
        setPhase <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      irqPend <= 1'b0;
    end else if (hitIn && chIrqEn) begin
      irqPend <= 1'b1;
    end else if (wrStat && wdata[STAT_B]) begin
      irqPend <= 1'b0;
    end
  end

  always_comb begin
    stb          = '0;
    stb.cntLoad  = wrEn && (addr == RA_CNT);
    stb.cmpLoad  = wrCmp && !(chSetVal && setPhase);
    stb.perLoad  = wrCmp && (!chSetVal || setPhase);
    stb.run      = genRun;
    stb.periodic = chPeriodic;
  end

  always_comb begin
    rdata = '0;
    case (regAddrE'(addr))
      RA_CAP:   rdata[0] = LEGACY_CAP;
      RA_GEN: begin
        rdata[GEN_RUN_B] = genRun;
        rdata[GEN_LEG_B] = genLegacy;
      end
      RA_STAT:  rdata[STAT_B] = irqPend;
      RA_CNT:   rdata = cntIn;
      RA_CHCFG: begin
        rdata[CH_IRQEN_B] = chIrqEn;
        rdata[CH_PER_B]   = chPeriodic;
        rdata[CH_SETV_B]  = chSetVal;
        rdata[CH_M32_B]   = chMode32;
      end
      RA_CMP:   rdata = cmpIn;
      RA_PER:   rdata = perIn;
      default:  rdata = '0;
    endcase
  end

  assign irqOut = irqPend;

  AST_SETVAL_SELF_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    (wrCmp && chSetVal && setPhase && !wrChCfg) |=> !chSetVal); // R5
  AST_SETVAL_HOLD_FIRST: assert property (@(posedge clk) disable iff (!rstN)
    (wrCmp && chSetVal && !setPhase) |=> chSetVal); // R5
  AST_PEND_ON_HIT: assert property (@(posedge clk) disable iff (!rstN)
    (hitIn && chIrqEn) |=> irqPend); // R8
  AST_NO_PEND_MASKED: assert property (@(posedge clk) disable iff (!rstN)
    (!irqPend && !(hitIn && chIrqEn)) |=> !irqPend); // R8

endmodule

// File: rtl/cmp_timer.sv
module cmp_timer
  import cmp_timer_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter bit LEGACY_CAP = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [2:0]        addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              irq
);

  dpStrobeT          stb;
  logic [DATA_W-1:0] count, cmpVal, perVal;
  logic              hit;

  cmp_timer_ctrl #(.DATA_W(DATA_W), .LEGACY_CAP(LEGACY_CAP)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wdata(wdata),
    .hitIn(hit), .cntIn(count), .cmpIn(cmpVal), .perIn(perVal),
    .stb(stb), .rdata(rdata), .irqOut(irq)
  );

  cmp_timer_dp #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .wdata(wdata),
    .count(count), .cmpVal(cmpVal), .perVal(perVal), .hit(hit)
  );

endmodule

// File: tb/cmp_timer_bench.sv
module cmp_timer_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [2:0]  addr = 3'd0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  cmp_timer u_cmp_timer (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr),
    .wdata(wdata), .rdata(rdata), .irq(irq)
  );

  // entry: {write addr, write data, read addr, expected read}
  localparam int NV = 9;
  localparam logic [69:0] VEC [NV] = '{
    {3'd1, 32'hFFFF_FFFC, 3'd1, 32'h0000_0000},
    {3'd1, 32'h0000_0002, 3'd1, 32'h0000_0002},
    {3'd3, 32'h0000_1234, 3'd3, 32'h0000_1234},
    {3'd4, 32'hFFFF_FEB3, 3'd4, 32'h0000_0000},
    {3'd4, 32'h0000_010C, 3'd4, 32'h0000_010C},
    {3'd5, 32'h0000_0500, 3'd5, 32'h0000_0500},
    {3'd5, 32'h0000_0700, 3'd6, 32'h0000_0700},
    {3'd0, 32'hFFFF_FFFF, 3'd0, 32'h0000_0001},
    {3'd2, 32'h0000_0001, 3'd2, 32'h0000_0000}
  };
  localparam string VTAG [NV] = '{"R2", "R2", "R1", "R3", "R3", "R4", "R4", "R2", "R8"};

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // called in the low phase; returns in the low phase after the write edge
  task automatic regWr(input logic [2:0] a, input logic [31:0] d);
    wrEn = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic regRd(input logic [2:0] a, output logic [31:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  task automatic finishRun();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    finishRun();
  end

  initial begin
    logic [31:0] v, v2;
    int startCyc, lastHit, nHits, waitCnt;

    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // reset state, R1
    regRd(3'd0, v); check("R2 reset cap", v, 32'h1);
    regRd(3'd1, v); check("R1 reset gen", v, 32'h0);
    regRd(3'd2, v); check("R8 reset status", v, 32'h0);
    regRd(3'd4, v); check("R3 reset chcfg", v, 32'h0);
    regRd(3'd5, v); check("R1 reset cmp", v, 32'hFFFF_FFFF);
    regRd(3'd6, v); check("R1 reset period", v, 32'h0);
    repeat (4) @(negedge clk);
    regRd(3'd3, v); check("R1 stopped counter", v, 32'h0);
    check("R8 reset irq", {31'd0, irq}, 32'h0);

    // vector table
    for (int i = 0; i < NV; i++) begin
      regWr(VEC[i][69:67], VEC[i][66:35]);
      regRd(VEC[i][34:32], v);
      check($sformatf("%s table %0d", VTAG[i], i), v, VEC[i][31:0]);
    end

    // periodic setup from a nonzero counter, R5 and R6
    regWr(3'd3, 32'd1000);
    regWr(3'd4, 32'h0000_014C);
    regRd(3'd4, v); check("R3 chcfg setval", v, 32'h14C);
    regWr(3'd5, 32'd1040);
    regRd(3'd4, v); check("R5 setval after first write", v, 32'h14C);
    regRd(3'd6, v); check("R5 period untouched by first write", v, 32'h700);
    regWr(3'd5, 32'd40);
    regRd(3'd4, v); check("R5 setval self clear", v, 32'h10C);
    regRd(3'd5, v); check("R5 comparator", v, 32'd1040);
    regRd(3'd6, v); check("R5 period", v, 32'd40);
    regWr(3'd2, 32'h1);
    regWr(3'd1, 32'h3);
    startCyc = cyc;
    lastHit = -1;
    nHits = 0;
    waitCnt = 0;
    while (nHits < 4 && waitCnt < 400) begin
      @(negedge clk);
      waitCnt++;
      if (irq) begin
        if (lastHit < 0) check("R6 first interrupt delay", cyc - startCyc, 32'd41);
        else check("R6 interrupt spacing", cyc - lastHit, 32'd40);
        lastHit = cyc;
        nHits++;
        regWr(3'd2, 32'h1);
      end
    end
    check("R6 interrupt count", nHits, 32'd4);
    regRd(3'd1, v); check("R2 legacy kept", v, 32'h3);
    regWr(3'd1, 32'h0);
    regRd(3'd3, v);
    repeat (5) @(negedge clk);
    regRd(3'd3, v2); check("R1 frozen counter", v2, v);

    // comparator below a fresh counter does not fire, R7
    regWr(3'd4, 32'h0000_0004);
    regWr(3'd3, 32'd100);
    regWr(3'd5, 32'd50);
    regWr(3'd2, 32'h1);
    regWr(3'd1, 32'h1);
    repeat (200) @(negedge clk);
    check("R7 passed comparator silent", {31'd0, irq}, 32'h0);
    regRd(3'd3, v); check("R1 counter advance", v, 32'd300);
    regWr(3'd1, 32'h0);

    // wrap around and wrapped reload, R6 R7 R8
    regWr(3'd4, 32'h0000_014C);
    regWr(3'd3, 32'hFFFF_FFF8);
    regWr(3'd5, 32'd3);
    regWr(3'd5, 32'd5);
    regWr(3'd2, 32'h1);
    regWr(3'd1, 32'h1);
    repeat (11) @(negedge clk);
    check("R7 before wrap match", {31'd0, irq}, 32'h0);
    @(negedge clk);
    check("R7 wrap match", {31'd0, irq}, 32'h1);
    regRd(3'd5, v); check("R6 reload after wrap", v, 32'd8);
    regWr(3'd2, 32'h0);
    regRd(3'd2, v); check("R8 write zero keeps status", v, 32'h1);
    regWr(3'd2, 32'h1);
    check("R8 write one clears", {31'd0, irq}, 32'h0);
    repeat (2) @(negedge clk);
    check("R6 before second match", {31'd0, irq}, 32'h0);
    @(negedge clk);
    check("R6 second match", {31'd0, irq}, 32'h1);
    regWr(3'd4, 32'h0000_0008);
    regWr(3'd2, 32'h1);
    repeat (20) @(negedge clk);
    check("R8 masked match irq", {31'd0, irq}, 32'h0);
    regRd(3'd2, v); check("R8 masked match status", v, 32'h0);

    finishRun();
  end

endmodule